// File: doc/BRIEF.md
# Checkpointed Return Address Stack

This block predicts return targets for a pipelined instruction fetch unit. Each lookup presents a PC and a two-bit branch class. A call pushes its fall-through address onto a small circular stack. A return reads the top entry as its predicted target and then pops it. Conditional and unconditional branches leave the stack untouched. When no prediction is available the target output is zero.

Every lookup also emits a checkpoint token. The token holds the stack pointer and the top entry as they stood before that lookup changed anything. Several lookups can be in flight before the first of them resolves. When an older branch turns out to be mispredicted, the pipeline hands its token back on the recover port. The block then restores the pointer and top entry, and replays the stack effect of that branch. One cycle later it presents the actual next PC as a fetch redirect. A completion port accepts every resolved branch. It leaves the speculative stack alone and reports, one cycle later, whether a completed return was predicted correctly.

Top module: `cra_top`

## Requirements
- R1: After reset the pointer is 0 and every entry is zero. A return lookup then yields target 0, and the token reads pointer 0 and top 0.
- R2: The class encoding is 2'b00 conditional, 2'b01 unconditional, 2'b10 call and 2'b11 return. Conditional and unconditional lookups give target 0 and do not change the stack.
- R3: A call lookup gives target 0, advances the pointer by one and writes PC+4 into the new top entry.
- R4: In the cycle of a return lookup, the target output equals the top entry. After the clock edge the pointer is one lower. Entries are never cleared by a pop.
- R5: During a lookup cycle, the token outputs show the pointer and the top entry as they were before that lookup.
- R6: The pointer wraps modulo DEPTH (DEPTH is a power of two). A push past the last slot overwrites the oldest entry without stalling.
- R7: A recovery writes the token's top value into the entry selected by the token's pointer and takes that pointer as the base. It then applies the recovered branch's own class: a call pushes its PC+4, a return pops, and any other class leaves the base in place.
- R8: When a recovery and a lookup arrive in the same cycle, the lookup has no effect on the stack and its target output is 0.
- R9: One cycle after a recovery, redir_valid is high and redir_pc equals that recovery's actual next PC. In every other cycle redir_valid is low.
- R10: A completion never changes the stack. One cycle after a completion of class return whose predicted PC equals its actual next PC, ret_ok is high; otherwise it is low.
- R11: With DEPTH set to 0, the target and both token outputs are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_class | input | 2 | Branch class of the lookup |
| lk_pc | input | AW | PC of the looked-up branch |
| lk_target | output | AW | Predicted return target, 0 if none |
| lk_tok_ptr | output | PW | Token: pointer before this lookup |
| lk_tok_top | output | AW | Token: top entry before this lookup |
| rc_valid | input | 1 | Recovery request |
| rc_tok_ptr | input | PW | Token pointer from the matching lookup |
| rc_tok_top | input | AW | Token top entry from the matching lookup |
| rc_class | input | 2 | Class of the mispredicted branch |
| rc_pc | input | AW | PC of the mispredicted branch |
| rc_next_pc | input | AW | Actual next PC after that branch |
| cm_valid | input | 1 | Completion of a resolved branch |
| cm_class | input | 2 | Class of the completed branch |
| cm_pred_pc | input | AW | PC that was predicted for it |
| cm_next_pc | input | AW | PC that actually followed it |
| redir_valid | output | 1 | Fetch redirect, one cycle after recovery |
| redir_pc | output | AW | Redirect address |
| ret_ok | output | 1 | Completed return was predicted correctly |

## Verification
Recovery and lookup compete for the stack in the same cycle. The bench drives both together, in directed steps and in a randomized stretch. It checks that the lookup's target output reads zero, and that the later return targets match a reference model in which only the recovery took effect. Completion can also fall in the same cycle as a lookup or a recovery. The model keeps the stack blind to completions, so any leak shows up as a wrong return target or token in a following cycle.

// File: rtl/cra_pkg.sv
package cra_pkg;

  typedef enum logic [1:0] {
    BR_COND = 2'b00,
    BR_JUMP = 2'b01,
    BR_CALL = 2'b10,
    BR_RET  = 2'b11
  } br_class_e;

  typedef enum logic [1:0] {
    STK_HOLD = 2'b00,
    STK_PUSH = 2'b01,
    STK_POP  = 2'b10
  } stk_op_e;

  // Stack effect of a branch class.
  function automatic stk_op_e class_to_op(input logic [1:0] cls);
    case (br_class_e'(cls))
      BR_CALL: class_to_op = STK_PUSH;
      BR_RET:  class_to_op = STK_POP;
      default: class_to_op = STK_HOLD;
    endcase
  endfunction

  // Whether a completion reports a correctly predicted return.
  function automatic logic ret_matches(input logic [1:0] cls, input logic same_pc);
    ret_matches = (br_class_e'(cls) == BR_RET) && same_pc;
  endfunction

endpackage

// File: rtl/cra_stack.sv
module cra_stack
  import cra_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int PW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fix_en,
  input  logic [PW-1:0] fix_ptr,
  input  logic [AW-1:0] fix_top,
  input  stk_op_e       step,
  input  logic [AW-1:0] push_val,
  output logic [PW-1:0] top_ptr,
  output logic [AW-1:0] top_val
);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] base_ptr;
  logic [PW-1:0] up_ptr;
  logic [PW-1:0] dn_ptr;
  logic [PW-1:0] nxt_ptr;
  logic          push_fire;
  logic          pop_fire;

  function automatic logic [PW-1:0] ring_step(input logic [PW-1:0] p, input logic up);
    ring_step = up ? p + PW'(1) : p - PW'(1);
  endfunction

  assign base_ptr  = fix_en ? fix_ptr : ptr_q;
  assign up_ptr    = ring_step(base_ptr, 1'b1);
  assign dn_ptr    = ring_step(base_ptr, 1'b0);
  assign push_fire = (step == STK_PUSH);
  assign pop_fire  = (step == STK_POP);

  always_comb begin
    case (step)
      STK_PUSH: nxt_ptr = up_ptr;
      STK_POP:  nxt_ptr = dn_ptr;
      default:  nxt_ptr = base_ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      ptr_q <= nxt_ptr;
      for (int i = 0; i < DEPTH; i++) begin
        if (push_fire && (PW'(i) == up_ptr))
          mem[i] <= push_val;
        else if (fix_en && (PW'(i) == fix_ptr))
          mem[i] <= fix_top;
      end
    end
  end

  assign top_ptr = ptr_q;
  assign top_val = mem[ptr_q];

  // R3
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> (top_val == $past(push_val)));

  // R4
  pop_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> (top_ptr == $past(base_ptr) - PW'(1)));

  // R7
  fix_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en && step == STK_HOLD) |=> (top_ptr == $past(fix_ptr) && top_val == $past(fix_top)));

endmodule

// File: rtl/cra_lookup.sv
module cra_lookup
  import cra_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 3
) (
  input  logic          lk_valid,
  input  logic [1:0]    lk_class,
  input  logic [AW-1:0] lk_pc,
  input  logic          rc_valid,
  input  logic [1:0]    rc_class,
  input  logic [AW-1:0] rc_pc,
  input  logic [AW-1:0] cur_top,
  output stk_op_e       step,
  output logic [AW-1:0] push_val,
  output logic [AW-1:0] target,
  output logic          lk_taken
);

  function automatic logic [AW-1:0] fall_through(input logic [AW-1:0] pc);
    fall_through = pc + AW'(4);
  endfunction

  assign lk_taken = lk_valid && !rc_valid;

  always_comb begin
    if (rc_valid) begin
      step     = class_to_op(rc_class);
      push_val = fall_through(rc_pc);
    end else if (lk_valid) begin
      step     = class_to_op(lk_class);
      push_val = fall_through(lk_pc);
    end else begin
      step     = STK_HOLD;
      push_val = fall_through(lk_pc);
    end
  end

  assign target = (lk_taken && br_class_e'(lk_class) == BR_RET) ? cur_top : '0;

endmodule

// File: rtl/cra_resolve.sv
module cra_resolve
  import cra_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rc_valid,
  input  logic [AW-1:0] rc_next_pc,
  input  logic          cm_valid,
  input  logic [1:0]    cm_class,
  input  logic [AW-1:0] cm_pred_pc,
  input  logic [AW-1:0] cm_next_pc,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc,
  output logic          ret_ok
);

  logic cm_hit;
  assign cm_hit = cm_valid && ret_matches(cm_class, cm_pred_pc == cm_next_pc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      ret_ok      <= 1'b0;
    end else begin
      redir_valid <= rc_valid;
      if (rc_valid) redir_pc <= rc_next_pc;
      ret_ok      <= cm_hit;
    end
  end

  // R9
  redir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rc_valid |=> (redir_valid && redir_pc == $past(rc_next_pc)));

  // R10
  retok_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_valid |=> !ret_ok);

endmodule

// File: rtl/cra_top.sv
module cra_top
  import cra_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [1:0]    lk_class,
  input  logic [AW-1:0] lk_pc,
  output logic [AW-1:0] lk_target,
  output logic [PW-1:0] lk_tok_ptr,
  output logic [AW-1:0] lk_tok_top,
  input  logic          rc_valid,
  input  logic [PW-1:0] rc_tok_ptr,
  input  logic [AW-1:0] rc_tok_top,
  input  logic [1:0]    rc_class,
  input  logic [AW-1:0] rc_pc,
  input  logic [AW-1:0] rc_next_pc,
  input  logic          cm_valid,
  input  logic [1:0]    cm_class,
  input  logic [AW-1:0] cm_pred_pc,
  input  logic [AW-1:0] cm_next_pc,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc,
  output logic          ret_ok
);

  generate
    if (DEPTH > 0) begin : g_on
      stk_op_e       step;
      logic [AW-1:0] push_val;
      logic [PW-1:0] cur_ptr;
      logic [AW-1:0] cur_top;
      logic          lk_taken;

      cra_lookup #(.AW(AW), .PW(PW)) u_lookup (
        .lk_valid (lk_valid),
        .lk_class (lk_class),
        .lk_pc    (lk_pc),
        .rc_valid (rc_valid),
        .rc_class (rc_class),
        .rc_pc    (rc_pc),
        .cur_top  (cur_top),
        .step     (step),
        .push_val (push_val),
        .target   (lk_target),
        .lk_taken (lk_taken)
      );

      cra_stack #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .fix_en   (rc_valid),
        .fix_ptr  (rc_tok_ptr),
        .fix_top  (rc_tok_top),
        .step     (step),
        .push_val (push_val),
        .top_ptr  (cur_ptr),
        .top_val  (cur_top)
      );

      assign lk_tok_ptr = cur_ptr;
      assign lk_tok_top = cur_top;

      // R8
      rc_over_lk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_valid && lk_valid) |-> (!lk_taken && lk_target == '0));

      // R5
      tok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_valid && !rc_valid) |=> (lk_tok_ptr == $past(lk_tok_ptr)
                                      && lk_tok_top == $past(lk_tok_top)));
    end else begin : g_off
      assign lk_target  = '0;
      assign lk_tok_ptr = '0;
      assign lk_tok_top = '0;

      // R11
      off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_target == '0));
    end
  endgenerate

  cra_resolve #(.AW(AW)) u_resolve (
    .clk         (clk),
    .rst_n       (rst_n),
    .rc_valid    (rc_valid),
    .rc_next_pc  (rc_next_pc),
    .cm_valid    (cm_valid),
    .cm_class    (cm_class),
    .cm_pred_pc  (cm_pred_pc),
    .cm_next_pc  (cm_next_pc),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .ret_ok      (ret_ok)
  );

  // R2
  nonret_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_class_e'(lk_class) != BR_RET) |-> (lk_target == '0));

endmodule

// File: tb/cra_top_test.sv
`timescale 1ns/1ps
module cra_top_test;

  localparam int DEPTH = 8;
  localparam int AW    = 32;
  localparam int PW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          lk_valid = 0, rc_valid = 0, cm_valid = 0;
  logic [1:0]    lk_class = 0, rc_class = 0, cm_class = 0;
  logic [AW-1:0] lk_pc = 0, rc_tok_top = 0, rc_pc = 0, rc_next_pc = 0;
  logic [AW-1:0] cm_pred_pc = 0, cm_next_pc = 0;
  logic [PW-1:0] rc_tok_ptr = 0;

  logic [AW-1:0] lk_target, lk_tok_top, redir_pc;
  logic [PW-1:0] lk_tok_ptr;
  logic          redir_valid, ret_ok;

  logic [AW-1:0] off_target, off_tok_top, off_redir_pc;
  logic [0:0]    off_tok_ptr;
  logic          off_redir_valid, off_ret_ok;

  cra_top #(.DEPTH(DEPTH), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_class(lk_class), .lk_pc(lk_pc),
    .lk_target(lk_target), .lk_tok_ptr(lk_tok_ptr), .lk_tok_top(lk_tok_top),
    .rc_valid(rc_valid), .rc_tok_ptr(rc_tok_ptr), .rc_tok_top(rc_tok_top),
    .rc_class(rc_class), .rc_pc(rc_pc), .rc_next_pc(rc_next_pc),
    .cm_valid(cm_valid), .cm_class(cm_class), .cm_pred_pc(cm_pred_pc),
    .cm_next_pc(cm_next_pc),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .ret_ok(ret_ok)
  );

  cra_top #(.DEPTH(0), .AW(AW)) uut_off (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_class(lk_class), .lk_pc(lk_pc),
    .lk_target(off_target), .lk_tok_ptr(off_tok_ptr), .lk_tok_top(off_tok_top),
    .rc_valid(rc_valid), .rc_tok_ptr(1'b0), .rc_tok_top(rc_tok_top),
    .rc_class(rc_class), .rc_pc(rc_pc), .rc_next_pc(rc_next_pc),
    .cm_valid(cm_valid), .cm_class(cm_class), .cm_pred_pc(cm_pred_pc),
    .cm_next_pc(cm_next_pc),
    .redir_valid(off_redir_valid), .redir_pc(off_redir_pc), .ret_ok(off_ret_ok)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Behavioural reference: ring of return addresses and an integer index.
  logic [AW-1:0] ref_ring [DEPTH];
  int            ref_idx;
  logic          exp_rv, exp_ok;
  logic [AW-1:0] exp_rpc;
  int            sv_idx;
  logic [AW-1:0] sv_top;

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic lv, input logic [1:0] lc, input logic [AW-1:0] lp,
                     input logic rv, input int rptr, input logic [AW-1:0] rtop,
                     input logic [1:0] rc, input logic [AW-1:0] rp, input logic [AW-1:0] rn,
                     input logic cv, input logic [1:0] cc, input logic [AW-1:0] cpp,
                     input logic [AW-1:0] cnp);
    int base;
    logic [1:0] cls;
    logic [AW-1:0] bpc;
    string tag;
    @(negedge clk);
    // registered outputs from the previous cycle
    check("R9 redir_valid", AW'(redir_valid), AW'(exp_rv));
    if (exp_rv) check("R9 redir_pc", redir_pc, exp_rpc);
    check("R10 ret_ok", AW'(ret_ok), AW'(exp_ok));
    lk_valid = lv; lk_class = lc; lk_pc = lp;
    rc_valid = rv; rc_tok_ptr = PW'(rptr); rc_tok_top = rtop;
    rc_class = rc; rc_pc = rp; rc_next_pc = rn;
    cm_valid = cv; cm_class = cc; cm_pred_pc = cpp; cm_next_pc = cnp;
    #1;
    if (rv && lv) tag = "R8 target";
    else if (lc == 2'b11) tag = "R4 target";
    else if (lc == 2'b10) tag = "R3 target";
    else tag = "R2 target";
    check(tag, lk_target, (lv && !rv && lc == 2'b11) ? ref_ring[ref_idx] : '0);
    check("R5 tok_ptr", AW'(lk_tok_ptr), AW'(ref_idx));
    check("R5 tok_top", lk_tok_top, ref_ring[ref_idx]);
    check("R11 off target", off_target | off_tok_top | AW'(off_tok_ptr), '0);
    sv_idx = ref_idx; sv_top = ref_ring[ref_idx];
    // reference update
    base = -1; cls = 2'b00; bpc = '0;
    if (rv) begin
      ref_ring[rptr] = rtop; base = rptr; cls = rc; bpc = rp;
    end else if (lv) begin
      base = ref_idx; cls = lc; bpc = lp;
    end
    if (base >= 0) begin
      if (cls == 2'b10) begin
        ref_idx = (base + 1) % DEPTH;
        ref_ring[ref_idx] = bpc + 4;
      end else if (cls == 2'b11) begin
        ref_idx = (base + DEPTH - 1) % DEPTH;
      end else begin
        ref_idx = base;
      end
    end
    exp_rv  = rv;
    if (rv) exp_rpc = rn;
    exp_ok  = cv && cc == 2'b11 && cpp == cnp;
    @(posedge clk);
  endtask

  task automatic lk(input logic [1:0] c, input logic [AW-1:0] pc);
    cyc(1, c, pc, 0, 0, '0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  task automatic idle();
    cyc(0, 0, '0, 0, 0, '0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int t_idx;
    logic [AW-1:0] t_top;
    int q_idx [$];
    logic [AW-1:0] q_top [$];
    for (int i = 0; i < DEPTH; i++) ref_ring[i] = '0;
    ref_idx = 0; exp_rv = 0; exp_ok = 0; exp_rpc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state seen through token and a return lookup
    check("R1 tok_ptr", AW'(lk_tok_ptr), '0);
    check("R1 tok_top", lk_tok_top, '0);
    lk(2'b11, 32'h40);
    idle();

    // R3 / R4: nested calls and returns
    lk(2'b10, 32'h100);
    lk(2'b00, 32'h150);
    lk(2'b10, 32'h200);
    lk(2'b01, 32'h250);
    lk(2'b10, 32'h300);
    lk(2'b11, 32'h900);
    lk(2'b11, 32'h904);
    lk(2'b11, 32'h908);

    // R6: overflow wraps and overwrites the oldest entry
    for (int i = 0; i < DEPTH + 3; i++) lk(2'b10, 32'h1000 + 32'(i * 16));
    for (int i = 0; i < DEPTH + 1; i++) lk(2'b11, 32'h2000);

    // R7: recovery of a call after younger lookups changed the stack
    lk(2'b10, 32'h3000);
    t_idx = sv_idx; t_top = sv_top;
    lk(2'b11, 32'h3100);
    lk(2'b11, 32'h3200);
    lk(2'b10, 32'h3300);
    cyc(0, 0, '0, 1, t_idx, t_top, 2'b10, 32'h3000, 32'h5000, 0, 0, '0, '0);
    lk(2'b11, 32'h3400);
    // R7: recovery of a return and of a conditional branch
    lk(2'b10, 32'h3500);
    lk(2'b11, 32'h3600);
    t_idx = sv_idx; t_top = sv_top;
    lk(2'b10, 32'h3700);
    cyc(0, 0, '0, 1, t_idx, t_top, 2'b11, 32'h3600, 32'h3504, 0, 0, '0, '0);
    cyc(0, 0, '0, 1, t_idx, t_top, 2'b00, 32'h3600, 32'h3604, 0, 0, '0, '0);
    lk(2'b11, 32'h3800);

    // R8: recovery and lookup in the same cycle
    lk(2'b10, 32'h4000);
    t_idx = sv_idx; t_top = sv_top;
    lk(2'b10, 32'h4100);
    cyc(1, 2'b10, 32'h4200, 1, t_idx, t_top, 2'b01, 32'h4000, 32'h6000, 0, 0, '0, '0);
    cyc(1, 2'b11, 32'h4300, 1, t_idx, t_top, 2'b00, 32'h4000, 32'h6100, 0, 0, '0, '0);
    lk(2'b11, 32'h4400);

    // R10: completions, matching and not, do not touch the stack
    lk(2'b10, 32'h7000);
    cyc(0, 0, '0, 0, 0, '0, 0, '0, '0, 1, 2'b11, 32'h7004, 32'h7004);
    cyc(0, 0, '0, 0, 0, '0, 0, '0, '0, 1, 2'b11, 32'h7004, 32'h7008);
    cyc(0, 0, '0, 0, 0, '0, 0, '0, '0, 1, 2'b10, 32'h7100, 32'h7100);
    cyc(1, 2'b11, 32'h7200, 0, 0, '0, 0, '0, '0, 1, 2'b11, 32'h10, 32'h10);
    idle();

    // Mixed random traffic, recoveries using tokens from recent lookups
    for (int k = 0; k < 600; k++) begin
      logic lv, rv, cv;
      logic [1:0] lc, rc, cc;
      logic [AW-1:0] pc, p2;
      int pick;
      lv = ($urandom % 4) != 0;
      rv = (q_idx.size() > 0) && (($urandom % 6) == 0);
      cv = ($urandom % 3) == 0;
      lc = 2'($urandom); rc = 2'($urandom); cc = 2'($urandom);
      pc = {$urandom % 32'h10000, 2'b00};
      p2 = ($urandom % 2) ? pc : pc + 4;
      pick = rv ? ($urandom % q_idx.size()) : 0;
      if (rv)
        cyc(lv, lc, pc, 1, q_idx[pick], q_top[pick], rc, pc + 32'h40, p2,
            cv, cc, pc, p2);
      else
        cyc(lv, lc, pc, 0, 0, '0, 0, '0, '0, cv, cc, pc, p2);
      if (lv && !rv) begin
        q_idx.push_back(sv_idx); q_top.push_back(sv_top);
        if (q_idx.size() > 6) begin
          void'(q_idx.pop_front()); void'(q_top.pop_front());
        end
      end
    end
    idle();
    idle();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule